// File: doc/BRIEF.md
# Receive Frame Buffer with CRC Gating

This block sits directly behind the start-of-frame detector of an Ethernet-style receiver. It takes one byte per clock, marked by a valid flag, a first-byte marker and a last-byte marker. Every accepted byte is written into a circular packet store. In the same cycle the byte also advances a byte-wide CRC-32. No second pass over the frame is needed. On the last byte the running check decides the fate of the whole frame. A good frame becomes visible to the downstream reader, together with its two 6-byte address fields. A bad frame disappears without a trace, because the speculative write pointer is wound back.

Writes advance a shadow pointer. The reader only ever sees bytes up to the committed pointer. A frame that runs past the length limit is abandoned and flagged, and so is a frame that meets a full store.

Top module: `rx_frame_gate`

## Requirements
- R1: After reset, `rd_valid`, `frame_ok`, `frame_bad` and `overflow` are low, and `dst_addr` and `src_addr` are zero.
- R2: A frame starts only on a valid byte with `in_sof` high. Valid bytes that arrive while no frame is open and that have no `in_sof` are ignored and never reach the reader.
- R3: The CRC register is preset to all ones and uses the reflected polynomial 0xEDB88320. The sender appends the complement of the final register, least significant byte first. A frame is good exactly when the register, after the byte carrying `in_eof`, equals 0xDEBB20E3. `frame_ok` or `frame_bad` pulses for one cycle, in the cycle after the edge that takes the last byte.
- R4: A good frame is committed whole, its 4 check bytes included. The reader pops the bytes in arrival order: `rd_data` is valid while `rd_valid` is high, and a byte is removed on a clock edge with `rd_en` high.
- R5: A bad frame is discarded. None of its bytes ever reach the reader, and its space is reused by the next frame.
- R6: `rd_valid` never reflects bytes of a frame that is still open.
- R7: `dst_addr` holds frame bytes 0 to 5 and `src_addr` holds bytes 6 to 11, with the earlier byte more significant. Both change only together with a `frame_ok` pulse.
- R8: A frame of up to `MAX_LEN` bytes is accepted. The byte that would be number `MAX_LEN`+1 drops the frame and pulses `overflow` for one cycle. The remaining bytes up to the next `in_sof` are ignored, and neither `frame_ok` nor `frame_bad` is raised, even when that byte carries `in_eof`.
- R9: A byte that arrives while the store holds 2^`ADDR_W`-1 bytes drops the frame in the same way as R8. Committed bytes are kept.
- R10: An `in_sof` inside an open frame silently discards the partial frame and starts a new one with that byte.
- R11: The reader may pop in the same cycle that a frame is committed, and both actions take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last check byte of a frame |
| in_data | input | 8 | Input byte |
| rd_en | input | 1 | Pop the byte at the head |
| rd_valid | output | 1 | A committed byte is available |
| rd_data | output | 8 | Head byte of the committed data |
| frame_ok | output | 1 | One-cycle pulse: frame committed |
| frame_bad | output | 1 | One-cycle pulse: frame failed its check |
| overflow | output | 1 | One-cycle pulse: frame dropped for length or space |
| dst_addr | output | 48 | Destination address of the last committed frame |
| src_addr | output | 48 | Source address of the last committed frame |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the commit of a new frame and a pop by the reader. The bench provokes it by draining a committed frame while a second frame arrives and closes. The full byte stream read back must then equal both frames in order. The second pair is a length overflow and the end marker. The bench sends a frame one byte too long, whose extra byte also carries `in_eof`. It expects one overflow pulse, no good or bad pulse, and an empty reader.

// File: rtl/rx_frame_gate.sv
module rx_frame_gate #(
  parameter int ADDR_W  = 11,
  parameter int MAX_LEN = 1600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic        rd_en,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        frame_ok,
  output logic        frame_bad,
  output logic        overflow,
  output logic [47:0] dst_addr,
  output logic [47:0] src_addr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam logic [31:0] POLY    = 32'hEDB88320;
  localparam logic [31:0] RESIDUE = 32'hDEBB20E3;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, commit_ptr, rd_ptr;
  logic [LEN_W-1:0]  len;
  logic [31:0]       crc;
  logic              in_frame;
  logic [47:0]       dst_sh, src_sh;

  logic              start, take, full, too_long, drop, wr, last, good;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  cnt;
  logic [31:0]       crc_nx;
  logic [47:0]       dst_nx, src_nx, dst_pre, src_pre;

  assign start    = in_valid && in_sof;
  assign take     = in_valid && (in_sof || in_frame);
  assign base     = start ? commit_ptr : wr_ptr;
  assign cnt      = start ? '0 : len;
  assign full     = (base + 1'b1) == rd_ptr;
  assign too_long = cnt == LEN_W'(MAX_LEN);
  assign drop     = take && (full || too_long);
  assign wr       = take && !drop;
  assign crc_nx   = crc_step(start ? '1 : crc, in_data);
  assign last     = wr && in_eof;
  assign good     = last && (crc_nx == RESIDUE);

  assign dst_pre = start ? '0 : dst_sh;
  assign src_pre = start ? '0 : src_sh;
  assign dst_nx  = (wr && cnt < 6) ? {dst_pre[39:0], in_data} : dst_pre;
  assign src_nx  = (wr && cnt >= 6 && cnt < 12) ? {src_pre[39:0], in_data} : src_pre;

  assign rd_valid = rd_ptr != commit_ptr;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr) mem[base] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      commit_ptr <= '0;
      rd_ptr     <= '0;
      len        <= '0;
      crc        <= '1;
      in_frame   <= 1'b0;
      dst_sh     <= '0;
      src_sh     <= '0;
      frame_ok   <= 1'b0;
      frame_bad  <= 1'b0;
      overflow   <= 1'b0;
      dst_addr   <= '0;
      src_addr   <= '0;
    end else begin
      if (rd_en && rd_valid) rd_ptr <= rd_ptr + 1'b1;
      if (drop || (last && !good)) wr_ptr <= commit_ptr;
      else if (wr)                 wr_ptr <= base + 1'b1;
      if (good) commit_ptr <= base + 1'b1;
      if (drop)    in_frame <= 1'b0;
      else if (wr) in_frame <= !in_eof;
      if (wr) begin
        len    <= cnt + 1'b1;
        crc    <= crc_nx;
        dst_sh <= dst_nx;
        src_sh <= src_nx;
      end
      frame_ok  <= good;
      frame_bad <= last && !good;
      overflow  <= drop;
      if (good) begin
        dst_addr <= dst_nx;
        src_addr <= src_nx;
      end
    end
  end

  // R3
  ok_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_bad));

  // R8
  ovf_no_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !frame_ok && !frame_bad);

  // R4
  commit_only_on_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(commit_ptr) |-> frame_ok);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |-> $stable(dst_addr) && $stable(src_addr));

  // R6
  commit_behind_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ADDR_W'(commit_ptr - rd_ptr) <= ADDR_W'(wr_ptr - rd_ptr));

  // R9
  never_full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (wr_ptr != rd_ptr));
endmodule

// File: tb/rx_frame_gate_tb.sv
`timescale 1ns/1ps
module rx_frame_gate_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, rd_en = 0;
  logic [7:0] in_data = 0;
  logic rd_valid, frame_ok, frame_bad, overflow;
  logic [7:0] rd_data;
  logic [47:0] dst_addr, src_addr;

  rx_frame_gate dut_i (.clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_data, .rd_en,
    .rd_valid, .rd_data, .frame_ok, .frame_bad, .overflow, .dst_addr, .src_addr);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int n_ok = 0, n_bad = 0, n_ovf = 0;
  logic [7:0] frm [4096];
  logic [7:0] keep [4096];
  logic [7:0] rx [4096];

  always @(negedge clk) begin
    if (frame_ok) n_ok++;
    if (frame_bad) n_bad++;
    if (overflow) n_ovf++;
  end

  // {data length, seed, corruption: 0 none, 1 payload byte, 2 check byte}
  localparam logic [23:0] VEC [6] = '{
    {12'd60,  8'h11, 4'd0}, {12'd46,  8'h22, 4'd1}, {12'd64,  8'h33, 4'd0},
    {12'd8,   8'h44, 4'd0}, {12'd100, 8'h55, 4'd2}, {12'd200, 8'h66, 4'd0}};

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = '1;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ frm[k][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic build(input int dlen, input logic [7:0] seed, input int corrupt, output int n);
    logic [31:0] f;
    for (int k = 0; k < dlen; k++) frm[k] = 8'(seed * 7 + k * 13 + (k >> 3));
    f = ref_crc(dlen);
    for (int k = 0; k < 4; k++) frm[dlen + k] = f[8*k +: 8];
    n = dlen + 4;
    if (corrupt == 1) frm[dlen / 2] ^= 8'h10;
    if (corrupt == 2) frm[dlen + 1] ^= 8'h01;
  endtask

  task automatic send(input int n, input bit sof, input bit eof);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1; in_sof = sof && (k == 0); in_eof = eof && (k == n - 1); in_data = frm[k];
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic drain(input int n, output int got);
    int t = 0;
    got = 0;
    while (got < n && t < 4 * n + 100) begin
      @(negedge clk);
      if (rd_valid) begin rx[got] = rd_data; got++; rd_en = 1; end
      else rd_en = 0;
      t++;
    end
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic expect_addr(input int n);
    logic [47:0] d = 0, s = 0;
    for (int k = 0; k < n && k < 6; k++) d = {d[39:0], frm[k]};
    for (int k = 6; k < n && k < 12; k++) s = {s[39:0], frm[k]};
    check(dst_addr == d, "R7 dst", dst_addr, d);
    check(src_addr == s, "R7 src", src_addr, s);
  endtask

  task automatic compare_rx(input int n, input int off, input string req);
    int bad = 0, first = -1;
    for (int k = 0; k < n; k++) if (rx[off + k] !== frm[k]) begin bad++; if (first < 0) first = k; end
    check(bad == 0, req, (first < 0) ? 0 : rx[off + first], (first < 0) ? 0 : frm[first]);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n, got, o0, b0, v0, na;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(!rd_valid && !frame_ok && !frame_bad && !overflow, "R1 flags", {rd_valid, frame_ok, frame_bad, overflow}, 0);
    check(dst_addr == 0 && src_addr == 0, "R1 addr", dst_addr, 0);

    // R2: a good frame without start marker is ignored
    build(30, 8'h77, 0, n);
    send(n, 0, 1);
    @(negedge clk);
    check(!rd_valid && n_ok == 0 && n_bad == 0, "R2 ignored", {rd_valid, 8'(n_ok)}, 0);

    // table walk: R3 R4 R5 R7
    foreach (VEC[i]) begin
      int dl = int'(VEC[i][23:12]);
      int cr = int'(VEC[i][3:0]);
      o0 = n_ok; b0 = n_bad;
      build(dl, VEC[i][11:4], cr, n);
      send(n, 1, 1);
      @(negedge clk);
      if (cr == 0) begin
        check(n_ok == o0 + 1 && n_bad == b0, "R3 good verdict", n_ok - o0, 1);
        expect_addr(n);
        drain(n, got);
        check(got == n, "R4 length", got, n);
        compare_rx(n, 0, "R4 data");
      end else begin
        check(n_bad == b0 + 1 && n_ok == o0, "R3 bad verdict", n_bad - b0, 1);
        check(!rd_valid, "R5 discarded", rd_valid, 0);
      end
    end

    // R10 with R6: restart inside an open frame
    build(20, 8'h99, 0, n);
    send(10, 1, 0);
    check(!rd_valid, "R6 open frame hidden", rd_valid, 0);
    o0 = n_ok; b0 = n_bad;
    build(40, 8'hA5, 0, n);
    send(n, 1, 1);
    @(negedge clk);
    check(n_ok == o0 + 1 && n_bad == b0, "R10 restart verdict", n_ok - o0, 1);
    drain(n, got);
    check(got == n, "R10 length", got, n);
    compare_rx(n, 0, "R10 data");

    // R11: pop while the next frame commits
    build(60, 8'h3C, 0, na);
    send(na, 1, 1);
    for (int k = 0; k < na; k++) keep[k] = frm[k];
    build(20, 8'h5A, 0, n);
    fork
      send(n, 1, 1);
      drain(na + n, got);
    join
    begin
      int bad = 0;
      for (int k = 0; k < na; k++) if (rx[k] !== keep[k]) bad++;
      check(bad == 0 && got == na + n, "R11 first frame", bad, 0);
    end
    compare_rx(n, na, "R11 second frame");

    // R8 boundary accepted, then R9 full store
    o0 = n_ok; v0 = n_ovf;
    build(1596, 8'h12, 0, na);
    send(na, 1, 1);
    for (int k = 0; k < na; k++) keep[k] = frm[k];
    @(negedge clk);
    check(n_ok == o0 + 1 && n_ovf == v0, "R8 max length accepted", n_ok - o0, 1);
    o0 = n_ok; b0 = n_bad;
    build(596, 8'h34, 0, n);
    send(n, 1, 1);
    @(negedge clk);
    check(n_ovf == v0 + 1 && n_ok == o0 && n_bad == b0, "R9 full drop", n_ovf - v0, 1);
    for (int k = 0; k < na; k++) frm[k] = keep[k];
    drain(na, got);
    check(got == na, "R9 committed kept", got, na);
    compare_rx(na, 0, "R9 committed data");

    // R8: one byte too long, end marker on the dropped byte
    o0 = n_ok; b0 = n_bad; v0 = n_ovf;
    build(1597, 8'h56, 0, n);
    send(n, 1, 1);
    @(negedge clk);
    check(n_ovf == v0 + 1 && n_ok == o0 && n_bad == b0, "R8 too long", n_ovf - v0, 1);
    check(!rd_valid, "R8 nothing visible", rd_valid, 0);

    // R5: space reused after drops
    build(16, 8'h78, 0, n);
    send(n, 1, 1);
    drain(n, got);
    check(got == n, "R5 reuse length", got, n);
    compare_rx(n, 0, "R5 reuse data");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule